// File: doc/BRIEF.md
# Write-Through Data Cache with Load-Invalidate Mode

This block is the data-side cache of a small in-order processor. It sits between the memory stage of the pipeline and an external memory port. It is direct-mapped. Each line holds four 32-bit words. A load that hits returns its word combinationally, in the request cycle. A load that misses freezes the pipeline while the whole line is fetched word by word through a valid handshake. The requested word is then returned in the cycle after the last fetched word.

Stores never allocate a line. Each store is passed to the external memory at once as one byte-enabled write. If the store's line is resident, that line is dropped. In addition, the first load after any store is always refilled from memory. This is deliberately simple read-after-write handling that keeps the hit path short.

Two control bits taken from the processor status register select the operating mode. Bit 1 enables the cache. Bit 0 turns every load into a command that invalidates the line at the load's index, and the load then returns nothing useful.

Top module: `dcache_top`

## Requirements
- R1: After reset every line is invalid, so the first load to any address misses. During reset `stall`, `memWrite` and `memRdReq` are 0.
- R2: With `srCtl` = 2'b10, a load to a resident line whose tag matches returns the memory word on `rdData` in the same cycle. In that cycle `stall` is 0 and no external read is made, provided no store came before it since the last load.
- R3: A load miss raises `stall` in the request cycle. It then holds `memRdReq` high and fetches the four words of the line at line base + 4*k, for k = 0, 1, 2, 3 in that order. In the cycle after the fourth accepted word, `stall` drops and `rdData` carries the requested word.
- R4: With `srCtl[1]` = 0, every load refills. A line refilled while the cache is disabled is left invalid, so it misses again after the cache is enabled.
- R5: A store drives `memWrite`, `memWrAddr`, `memWrData` and `memWrByteEn` equal to the request in the same cycle. It raises no stall and starts no external read.
- R6: A store invalidates the resident line only when both the index and the tag match. A line at the same index with a different tag stays valid.
- R7: The first load after a store always refills, even when its own line is resident and different from the stored line.
- R8: With `srCtl[0]` = 1 (modes 2'b01 and 2'b11), a load makes no external access and raises no stall. It returns 0 on `rdData` and invalidates the line at its index whatever the tag.
- R9: During a refill, a word is captured only in cycles where `memRdValid` is 1. Cycles without it hold the fetch position.
- R10: After a refill, loads to all four words of the line hit and return the fetched data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqAddr | input | 32 | Byte address of the load or store; held while `stall` is 1 |
| reqRead | input | 1 | Load request |
| reqWrite | input | 1 | Store request (never together with `reqRead`) |
| reqByteEn | input | 4 | Store byte enables |
| reqWdata | input | 32 | Store data |
| srCtl | input | 2 | Mode: bit 1 cache enable, bit 0 load-invalidate |
| rdData | output | 32 | Load data, valid when a load completes |
| stall | output | 1 | Freezes every pipeline stage |
| memWrite | output | 1 | External write request |
| memWrAddr | output | 32 | External write address |
| memWrData | output | 32 | External write data |
| memWrByteEn | output | 4 | External write byte enables |
| memRdReq | output | 1 | External line-fetch request |
| memRdAddr | output | 32 | Address of the word being fetched |
| memRdValid | input | 1 | Fetched word present on `memRdData` |
| memRdData | input | 32 | Fetched word |

## Verification
The interaction that needs the most care is a store that issues its write-through and drops a resident line in the same cycle, followed by a load whose refill is forced by that store. The bench provokes this with stores whose address matches a resident line and with stores to the same index under a different tag. Each such store is followed by a load to an unrelated resident line and then by a load to the stored line. A behavioural reference model of line validity, tags and the pending-store flag predicts, for every load, whether it hits. For each refill it also predicts the exact sequence of fetch addresses and the returned data, including the bytes merged by the store. The port values are compared against those predictions cycle by cycle.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DONE = 2'd2
  } dcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fillWe;      // write fetched word into the line
    logic fillDone;    // last word: update tag and valid
    logic setValid;    // valid value written at fillDone
    logic invalidate;  // clear valid of the indexed line
    logic serve;       // drive the addressed word on rdData
  } dcStrobe_t;

endpackage

// File: rtl/dcache_dp.sv
module dcache_dp
  import dcache_pkg::*;
#(
  parameter int LADDR_W = 30,   // word address width
  parameter int DATA_W  = 32,
  parameter int LINES   = 16,
  parameter int WORDS   = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LADDR_W-1:0]   wordAddr,
  input  dcStrobe_t            strobe,
  input  logic [$clog2(WORDS)-1:0] fillWord,
  input  logic [DATA_W-1:0]    fillData,
  output logic                 hit,
  output logic [DATA_W-1:0]    rdData,
  output logic [LADDR_W-1:0]   fillWordAddr
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = LADDR_W - IDX_W - OFF_W;

  logic [OFF_W-1:0] wordSel;
  logic [IDX_W-1:0] lineIdx;
  logic [TAG_W-1:0] reqTag;

  assign wordSel = wordAddr[OFF_W-1:0];
  assign lineIdx = wordAddr[OFF_W +: IDX_W];
  assign reqTag  = wordAddr[LADDR_W-1 -: TAG_W];

  logic [LINES-1:0]         validVec;
  logic [TAG_W-1:0]         tagArr  [LINES];
  logic [WORDS*DATA_W-1:0]  dataArr [LINES];

  for (genvar l = 0; l < LINES; l++) begin : gLine
    logic                    lineValid;
    logic [TAG_W-1:0]        lineTag;
    logic [WORDS*DATA_W-1:0] lineData;
    logic                    lineSel;

    assign lineSel = (lineIdx == IDX_W'(l));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                            lineValid <= 1'b0;
      else if (strobe.fillDone && lineSel)  lineValid <= strobe.setValid;
      else if (strobe.invalidate && lineSel) lineValid <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (strobe.fillDone && lineSel) lineTag <= reqTag;
      if (strobe.fillWe && lineSel)
        lineData[int'(fillWord)*DATA_W +: DATA_W] <= fillData;
    end

    assign validVec[l] = lineValid;
    assign tagArr[l]   = lineTag;
    assign dataArr[l]  = lineData;
  end

  assign hit          = validVec[lineIdx] && (tagArr[lineIdx] == reqTag);
  assign rdData       = strobe.serve ? dataArr[lineIdx][int'(wordSel)*DATA_W +: DATA_W]
                                     : '0;
  assign fillWordAddr = {reqTag, lineIdx, fillWord};

  // a completed enabled refill makes the held request hit
  assert_fill_makes_hit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fillDone && strobe.setValid) |=> hit);

  // an invalidation removes the indexed line
  assert_inval_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.invalidate && !strobe.fillDone) |=> !validVec[$past(lineIdx)]);

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqRead,
  input  logic                     reqWrite,
  input  logic                     cacheEn,
  input  logic                     invMode,
  input  logic                     hit,
  input  logic                     fillValid,
  output dcStrobe_t                strobe,
  output logic [$clog2(WORDS)-1:0] fillWord,
  output logic                     stall,
  output logic                     memRdReq,
  output logic                     memWrite
);
  localparam int OFF_W = $clog2(WORDS);
  localparam logic [OFF_W-1:0] LAST_WORD = OFF_W'(WORDS - 1);

  dcState_t         state, nextState;
  logic [OFF_W-1:0] fillCnt, nextCnt;
  logic             storeSeen, nextStore;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      fillCnt   <= '0;
      storeSeen <= 1'b0;
    end else begin
      state     <= nextState;
      fillCnt   <= nextCnt;
      storeSeen <= nextStore;
    end
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextCnt   = fillCnt;
    nextStore = storeSeen;
    stall     = 1'b0;
    memRdReq  = 1'b0;
    memWrite  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqWrite) begin
          memWrite          = 1'b1;
          nextStore         = 1'b1;
          strobe.invalidate = hit;
        end else if (reqRead) begin
          if (invMode) begin
            strobe.invalidate = 1'b1;
          end else if (cacheEn && hit && !storeSeen) begin
            strobe.serve = 1'b1;
          end else begin
            stall     = 1'b1;
            nextState = ST_FILL;
            nextCnt   = '0;
          end
        end
      end
      ST_FILL: begin
        stall    = 1'b1;
        memRdReq = 1'b1;
        if (fillValid) begin
          strobe.fillWe = 1'b1;
          nextCnt       = fillCnt + 1'b1;
          if (fillCnt == LAST_WORD) begin
            strobe.fillDone = 1'b1;
            nextState       = ST_DONE;
          end
        end
      end
      ST_DONE: begin
        strobe.serve = 1'b1;
        nextStore    = 1'b0;
        nextState    = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
    strobe.setValid = cacheEn;
  end

  assign fillWord = fillCnt;

  // load right after a store cannot complete without a refill
  assert_store_then_refill_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqWrite) |=> (!(reqRead && !invMode) || stall));

  // disabled cache never serves a load from the array
  assert_disabled_refills_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && reqRead && !invMode && !cacheEn) |=> (state == ST_FILL));

  // fetch position holds across cycles without a word
  assert_gap_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FILL && !fillValid) |=> (state == ST_FILL && $stable(fillWord)));

  // completion lasts exactly one cycle
  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |=> (state == ST_IDLE && !stall));

endmodule

// File: rtl/dcache_top.sv
module dcache_top
  import dcache_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int WORDS  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqRead,
  input  logic                reqWrite,
  input  logic [DATA_W/8-1:0] reqByteEn,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [1:0]          srCtl,
  output logic [DATA_W-1:0]   rdData,
  output logic                stall,
  output logic                memWrite,
  output logic [ADDR_W-1:0]   memWrAddr,
  output logic [DATA_W-1:0]   memWrData,
  output logic [DATA_W/8-1:0] memWrByteEn,
  output logic                memRdReq,
  output logic [ADDR_W-1:0]   memRdAddr,
  input  logic                memRdValid,
  input  logic [DATA_W-1:0]   memRdData
);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int LADDR_W = ADDR_W - BYTE_W;
  localparam int OFF_W   = $clog2(WORDS);

  dcStrobe_t          strobe;
  logic [OFF_W-1:0]   fillWord;
  logic               hit;
  logic [LADDR_W-1:0] fillWordAddr;

  dcache_ctrl #(.WORDS(WORDS)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqRead  (reqRead),
    .reqWrite (reqWrite),
    .cacheEn  (srCtl[1]),
    .invMode  (srCtl[0]),
    .hit      (hit),
    .fillValid(memRdValid),
    .strobe   (strobe),
    .fillWord (fillWord),
    .stall    (stall),
    .memRdReq (memRdReq),
    .memWrite (memWrite)
  );

  dcache_dp #(
    .LADDR_W(LADDR_W),
    .DATA_W (DATA_W),
    .LINES  (LINES),
    .WORDS  (WORDS)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .wordAddr    (reqAddr[ADDR_W-1:BYTE_W]),
    .strobe      (strobe),
    .fillWord    (fillWord),
    .fillData    (memRdData),
    .hit         (hit),
    .rdData      (rdData),
    .fillWordAddr(fillWordAddr)
  );

  assign memWrAddr   = reqAddr;
  assign memWrData   = reqWdata;
  assign memWrByteEn = reqByteEn;
  assign memRdAddr   = {fillWordAddr, {BYTE_W{1'b0}}};

  // write-through never stalls the pipeline
  assert_store_no_stall_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> (!stall && !memRdReq));

  // invalidate-mode load touches no external port
  assert_inv_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqRead && srCtl[0] && !stall && !$past(stall)) |=> !memRdReq);

  // pipeline holds its request while frozen
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(reqAddr));

  assert_rw_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(reqRead && reqWrite));

endmodule

// File: tb/sim_dcache_top.sv
`timescale 1ns/1ps
module sim_dcache_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        reqRead = 1'b0;
  logic        reqWrite = 1'b0;
  logic [3:0]  reqByteEn = '0;
  logic [31:0] reqWdata = '0;
  logic [1:0]  srCtl = 2'b10;
  logic [31:0] rdData;
  logic        stall;
  logic        memWrite;
  logic [31:0] memWrAddr;
  logic [31:0] memWrData;
  logic [3:0]  memWrByteEn;
  logic        memRdReq;
  logic [31:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;

  always #10 clk = ~clk;   // 50 MHz

  dcache_top u0 (
    .clk(clk), .rstN(rstN), .reqAddr(reqAddr), .reqRead(reqRead),
    .reqWrite(reqWrite), .reqByteEn(reqByteEn), .reqWdata(reqWdata),
    .srCtl(srCtl), .rdData(rdData), .stall(stall), .memWrite(memWrite),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .memWrByteEn(memWrByteEn),
    .memRdReq(memRdReq), .memRdAddr(memRdAddr), .memRdValid(memRdValid),
    .memRdData(memRdData)
  );

  // external memory
  logic [31:0] mem [1024];
  int  gapCtr = 0;
  bit  gapOn  = 1'b0;

  always @(negedge clk) begin
    if (memRdReq) begin
      gapCtr++;
      memRdValid = !(gapOn && (gapCtr % 3 == 1));
      memRdData  = mem[memRdAddr[11:2]];
    end else begin
      memRdValid = 1'b0;
    end
  end

  // reference model: 16 lines, 4 words, tag above bit 7
  bit          mValid [16];
  logic [23:0] mTag   [16];
  bit          mStore = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic doRead(input logic [31:0] a, input string rq);
    int   idx  = int'(a[7:4]);
    bit   expHit;
    int   nWords = 0;
    int   guard  = 0;
    logic [31:0] base = {a[31:4], 4'h0};
    expHit = srCtl[1] && mValid[idx] && (mTag[idx] == a[31:8]) && !mStore;
    @(posedge clk); #1;
    reqAddr = a; reqRead = 1'b1;
    @(negedge clk); #2;
    if (expHit) begin
      check(rq, "hit stall", {31'b0, stall}, 32'd0);
      check(rq, "hit rdReq", {31'b0, memRdReq}, 32'd0);
      check(rq, "hit data", rdData, mem[a[11:2]]);
    end else begin
      check(rq, "miss stall", {31'b0, stall}, 32'd1);
      while (stall && guard < 200) begin
        if (memRdReq && memRdValid) begin
          check(rq, "fetch addr", memRdAddr, base + 32'(4 * nWords));
          nWords++;
        end
        @(negedge clk); #2;
        guard++;
      end
      check(rq, "words fetched", 32'(nWords), 32'd4);
      check(rq, "refill data", rdData, mem[a[11:2]]);
      mValid[idx] = srCtl[1];
      mTag[idx]   = a[31:8];
      mStore      = 1'b0;
    end
    @(posedge clk); #1;
    reqRead = 1'b0;
  endtask

  task automatic doWrite(input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] be, input string rq);
    int idx = int'(a[7:4]);
    @(posedge clk); #1;
    reqAddr = a; reqWrite = 1'b1; reqWdata = d; reqByteEn = be;
    @(negedge clk); #2;
    check(rq, "wr strobe", {31'b0, memWrite}, 32'd1);
    check(rq, "wr addr", memWrAddr, a);
    check(rq, "wr data", memWrData, d);
    check(rq, "wr be", {28'b0, memWrByteEn}, {28'b0, be});
    check(rq, "wr stall", {30'b0, stall, memRdReq}, 32'd0);
    @(posedge clk); #1;
    reqWrite = 1'b0;
    for (int b = 0; b < 4; b++)
      if (be[b]) mem[a[11:2]][8*b +: 8] = d[8*b +: 8];
    if (mValid[idx] && mTag[idx] == a[31:8]) mValid[idx] = 1'b0;
    mStore = 1'b1;
  endtask

  task automatic doInv(input logic [31:0] a, input logic [1:0] mode, input string rq);
    logic [1:0] keep = srCtl;
    @(posedge clk); #1;
    srCtl = mode; reqAddr = a; reqRead = 1'b1;
    @(negedge clk); #2;
    check(rq, "inv quiet", {29'b0, stall, memRdReq, memWrite}, 32'd0);
    check(rq, "inv data", rdData, 32'd0);
    @(posedge clk); #1;
    reqRead = 1'b0; srCtl = keep;
    mValid[int'(a[7:4])] = 1'b0;
  endtask

  localparam logic [31:0] ADR_A = 32'h0000_0040;  // index 4
  localparam logic [31:0] ADR_B = 32'h0000_0080;  // index 8
  localparam logic [31:0] ADR_C = 32'h0000_0140;  // index 4, other tag

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 ^ (i * 32'h0101_0013);
    for (int i = 0; i < 16; i++) begin mValid[i] = 1'b0; mTag[i] = '0; end

    repeat (3) @(posedge clk);
    @(negedge clk); #2;
    check("R1", "reset outputs", {29'b0, stall, memWrite, memRdReq}, 32'd0);
    @(posedge clk); #1 rstN = 1'b1;

    doRead(ADR_A, "R1");            // cold miss
    doRead(ADR_A, "R2");
    doRead(ADR_A + 4, "R10");
    doRead(ADR_A + 8, "R10");
    doRead(ADR_A + 12, "R10");

    gapOn = 1'b1;
    doRead(ADR_B + 4, "R9");        // refill with gaps
    gapOn = 1'b0;
    doRead(ADR_B + 8, "R2");

    doWrite(ADR_C, 32'h1234_5678, 4'hF, "R5");   // same index, other tag
    doRead(ADR_B, "R7");            // forced refill though resident
    doRead(ADR_A + 4, "R6");        // still resident

    doWrite(ADR_A + 4, 32'hAABB_CCDD, 4'b0011, "R5");
    doRead(ADR_B + 12, "R7");
    doRead(ADR_A + 4, "R6");        // invalidated: refetch merged word

    doInv(ADR_C, 2'b01, "R8");      // other tag, same index
    doRead(ADR_A, "R8");
    doInv(ADR_B, 2'b11, "R8");
    doRead(ADR_B, "R8");

    srCtl = 2'b00;
    doRead(ADR_A, "R4");
    doRead(ADR_A, "R4");
    srCtl = 2'b10;
    doRead(ADR_A, "R4");            // left invalid while disabled
    doRead(ADR_A + 8, "R2");

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #4_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule